// File: doc/BRIEF.md
# SDRAM Four-Beat Auto-Precharge Read Sequencer

This block converts one read request from a host bus into the SDRAM command sequence for a four-word burst. The request carries a bank, a row and a column. The block first opens the row with an activate command. It then waits a fixed number of spacing cycles. After that it issues four single-beat column reads in consecutive cycles. The last of these reads carries auto-precharge. The four returned words are captured after a fixed CAS latency and handed back with a valid strobe and a beat tag.

When the last word has been captured, one data-end cycle follows and the sequencer goes idle. At that point the accessed bank enters a precharge wait, whose length is set by a 2-bit field. A value v gives v+1 cycles. During the wait, no new request to that bank is accepted. A request to any other bank is accepted at once, and so is an access to another chip-select space, which another controller serves while this one waits.

Top module: `sdram_burst_reader`

## Requirements
- R1: After reset, `sdCsN` is high, `rdValid` is low and `reqReady` is high.
- R2: In the first cycle after a request is accepted, the command pins {sdCsN,sdRasN,sdCasN,sdWeN} read 4'b0011 (activate), `sdAddr` holds the row and `sdBank` holds the bank.
- R3: ACT_WAIT no-operation cycles follow the activate. After them, four read commands (pins 4'b0101) go out in consecutive cycles. For beat b (0 to 3), `sdAddr[1:0]` equals b and `sdAddr[COL_W-1:2]` equals the request column's upper bits.
- R4: Address bit AP_BIT (bit 10) is low on the first three reads and high on the fourth.
- R5: In every cycle that issues no command, the command pins read 4'b1111 and `sdDqm` is all ones. `sdDqm` is all zeros on every read cycle.
- R6: Words sampled from `sdDq` CAS_LAT+1 rising edges after each read cycle are returned with `rdValid` high in four consecutive cycles, tagged 0,1,2,3 in order. The first valid cycle is ACT_WAIT+CAS_LAT+3 cycles after acceptance.
- R7: `reqReady` is low from acceptance until the sequencer is idle again. A `reqValid` pulse raised while `reqReady` is low changes no command output.
- R8: The sequencer is idle again ACT_WAIT+CAS_LAT+8 cycles after acceptance. From then on, `reqReady` for the same bank stays low for `apWait`+1 cycles.
- R9: In the first idle cycle after a burst, `reqReady` is high for any other bank that is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host read request present |
| reqReady | output | 1 | Request accepted this cycle if reqValid is high |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row to activate |
| reqCol | input | COL_W | Column; low two bits are replaced by the beat index |
| apWait | input | 2 | Precharge wait setting, v gives v+1 cycles |
| rdValid | output | 1 | Returned word valid |
| rdBeat | output | 2 | Beat index of the returned word |
| rdData | output | DATA_W | Returned word |
| sdCsN | output | 1 | Chip select, low when a command is issued |
| sdRasN | output | 1 | Row strobe |
| sdCasN | output | 1 | Column strobe |
| sdWeN | output | 1 | Write enable, always high |
| sdAddr | output | ADDR_W | Row or column address, AP_BIT marks auto-precharge |
| sdBank | output | BANK_W | Bank select |
| sdDqm | output | DATA_W/8 | Byte masks, low enables the byte |
| sdDq | input | DATA_W | Read data from the memory |

## Verification
Bursts are run on all four banks. The columns used have zero and nonzero low bits, so the beat addressing is shown to ignore the request's low column bits. Each of the precharge wait settings 0, 1, 2 and 3 is used, which separates a wait counter that is off by one from a correct one. Two bursts go back to back on the same bank, and in one burst a request for another bank is held valid through the busy phase; together these show that the same-bank hold and the early release for other banks are independent. The memory model returns words that encode bank, row and column, so a misplaced beat, a wrong row or a shifted latency shows up as a data mismatch.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_GAP, ST_READ, ST_DRAIN, ST_DEND
  } seqState_t;

  typedef struct packed {
    logic       latchReq;
    logic       doAct;
    logic       doRead;
    logic [1:0] beat;
    logic       lastRead;
  } seqStrobe_t;
endpackage

// File: rtl/sdrb_ctrl.sv
module sdrb_ctrl
  import sdrb_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ACT_WAIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [1:0]        apWait,
  input  logic              lastBeat,
  output logic              reqReady,
  output seqStrobe_t        strb
);
  localparam int NBANK = 1 << BANK_W;
  localparam int WC_W  = (ACT_WAIT > 1) ? $clog2(ACT_WAIT) : 1;

  seqState_t         state;
  logic [WC_W-1:0]   waitCnt;
  logic [1:0]        beat;
  logic [BANK_W-1:0] curBank;
  logic [2:0]        busyCnt [NBANK];
  logic              accept;

  assign reqReady = (state == ST_IDLE) && (busyCnt[reqBank] == 3'd0);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      beat    <= '0;
      curBank <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_ACT;
          curBank <= reqBank;
        end
        ST_ACT: begin
          beat <= '0;
          if (ACT_WAIT == 0) state <= ST_READ;
          else begin
            state   <= ST_GAP;
            waitCnt <= WC_W'((ACT_WAIT > 0) ? ACT_WAIT - 1 : 0);
          end
        end
        ST_GAP: if (waitCnt == '0) state <= ST_READ;
                else waitCnt <= waitCnt - 1'b1;
        ST_READ: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= ST_DRAIN;
        end
        ST_DRAIN: if (lastBeat) state <= ST_DEND;
        ST_DEND:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NBANK; i++) busyCnt[i] <= 3'd0;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        if (state == ST_DEND && curBank == BANK_W'(i))
          busyCnt[i] <= {1'b0, apWait} + 3'd1;
        else if (busyCnt[i] != 3'd0)
          busyCnt[i] <= busyCnt[i] - 3'd1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchReq = accept;
    strb.doAct    = (state == ST_ACT);
    strb.doRead   = (state == ST_READ);
    strb.beat     = beat;
    strb.lastRead = (state == ST_READ) && (beat == 2'd3);
  end
endmodule

// File: rtl/sdrb_datapath.sv
module sdrb_datapath
  import sdrb_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int ADDR_W  = 13,
  parameter int AP_BIT  = 10,
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] sdDq,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic [DATA_W/8-1:0] sdDqm,
  output logic              rdValid,
  output logic [1:0]        rdBeat,
  output logic [DATA_W-1:0] rdData,
  output logic              lastBeat
);
  logic [BANK_W-1:0]  bankQ;
  logic [ROW_W-1:0]   rowQ;
  logic [COL_W-1:0]   colQ;
  logic [CAS_LAT-1:0] pipeV;
  logic [1:0]         pipeB [CAS_LAT];
  logic [ADDR_W-1:0]  colAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
    end else if (strb.latchReq) begin
      bankQ <= reqBank;
      rowQ  <= reqRow;
      colQ  <= reqCol;
    end
  end

  always_comb begin
    colAddr              = '0;
    colAddr[COL_W-1:0]   = {colQ[COL_W-1:2], strb.beat};
    colAddr[AP_BIT]      = strb.lastRead;
  end

  assign sdCsN  = !(strb.doAct || strb.doRead);
  assign sdRasN = !strb.doAct;
  assign sdCasN = !strb.doRead;
  assign sdWeN  = 1'b1;
  assign sdBank = bankQ;
  assign sdDqm  = strb.doRead ? '0 : '1;
  assign sdAddr = strb.doAct ? ADDR_W'(rowQ) : (strb.doRead ? colAddr : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeV <= '0;
      for (int j = 0; j < CAS_LAT; j++) pipeB[j] <= '0;
    end else begin
      pipeV[0] <= strb.doRead;
      pipeB[0] <= strb.beat;
      for (int j = 1; j < CAS_LAT; j++) begin
        pipeV[j] <= pipeV[j-1];
        pipeB[j] <= pipeB[j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdBeat  <= '0;
      rdData  <= '0;
    end else begin
      rdValid <= pipeV[CAS_LAT-1];
      if (pipeV[CAS_LAT-1]) begin
        rdBeat <= pipeB[CAS_LAT-1];
        rdData <= sdDq;
      end
    end
  end

  assign lastBeat = rdValid && (rdBeat == 2'd3);
endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
  import sdrb_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int ADDR_W   = 13,
  parameter int AP_BIT   = 10,
  parameter int DATA_W   = 32,
  parameter int CAS_LAT  = 2,
  parameter int ACT_WAIT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [1:0]          apWait,
  output logic                rdValid,
  output logic [1:0]          rdBeat,
  output logic [DATA_W-1:0]   rdData,
  output logic                sdCsN,
  output logic                sdRasN,
  output logic                sdCasN,
  output logic                sdWeN,
  output logic [ADDR_W-1:0]   sdAddr,
  output logic [BANK_W-1:0]   sdBank,
  output logic [DATA_W/8-1:0] sdDqm,
  input  logic [DATA_W-1:0]   sdDq
);
  seqStrobe_t strb;
  logic       lastBeat;

  sdrb_ctrl #(.BANK_W(BANK_W), .ACT_WAIT(ACT_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .apWait(apWait), .lastBeat(lastBeat), .reqReady(reqReady), .strb(strb)
  );

  sdrb_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .sdDq(sdDq), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr), .sdBank(sdBank),
    .sdDqm(sdDqm), .rdValid(rdValid), .rdBeat(rdBeat), .rdData(rdData),
    .lastBeat(lastBeat)
  );
endmodule

// File: rtl/sdram_burst_reader_chk.sv
module sdram_burst_reader_chk #(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DQM_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [1:0]        rdBeat,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic [ADDR_W-1:0] sdAddr,
  input logic [DQM_W-1:0]  sdDqm
);
  logic isAct, isRd;
  assign isAct = !sdCsN && !sdRasN && sdCasN;
  assign isRd  = !sdCsN && sdRasN && !sdCasN;

  assert_gap_after_act_R3: assert property (@(posedge clk) disable iff (!rstN)
    isAct |=> (sdCsN || isRd));

  assert_plain_read_continues_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && !sdAddr[AP_BIT]) |=> isRd);

  assert_ap_read_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && sdAddr[AP_BIT]) |=> sdCsN);

  assert_mask_on_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    isRd |-> (sdDqm == '0));

  assert_mask_when_nop_R5: assert property (@(posedge clk) disable iff (!rstN)
    sdCsN |-> (&sdDqm));

  assert_beat_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdBeat != 2'd0) |-> ($past(rdValid) && rdBeat == $past(rdBeat) + 2'd1));

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> sdCsN);
endmodule

bind sdram_burst_reader sdram_burst_reader_chk #(
  .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DQM_W(DATA_W/8)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .rdBeat(rdBeat), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdAddr(sdAddr), .sdDqm(sdDqm)
);

// File: tb/sdram_burst_reader_bench.sv
`timescale 1ns/1ps
module sdram_burst_reader_bench;
  localparam int AW = 1;
  localparam int CL = 2;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqReady;
  logic [1:0]  reqBank = 0;
  logic [12:0] reqRow = 0;
  logic [8:0]  reqCol = 0;
  logic [1:0]  apWait = 0;
  logic        rdValid;
  logic [1:0]  rdBeat;
  logic [31:0] rdData;
  logic        sdCsN, sdRasN, sdCasN, sdWeN;
  logic [12:0] sdAddr;
  logic [1:0]  sdBank;
  logic [3:0]  sdDqm;
  logic [31:0] sdDq = 0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_burst_reader u_sdram_burst_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .apWait(apWait),
    .rdValid(rdValid), .rdBeat(rdBeat), .rdData(rdData), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr),
    .sdBank(sdBank), .sdDqm(sdDqm), .sdDq(sdDq)
  );

  function automatic logic [31:0] memWord(input logic [1:0] b, input logic [12:0] r,
                                          input logic [8:0] c);
    return {4'hA, b, r, c, 4'h5};
  endfunction

  // Memory model: opens rows on activate, returns a word CL+1 edges after a read.
  logic [12:0] openRow [4];
  logic [31:0] dqPipe [CL+1];
  initial begin
    for (int i = 0; i < 4; i++) openRow[i] = '0;
    for (int j = 0; j <= CL; j++) dqPipe[j] = '0;
  end
  always @(negedge clk) begin
    for (int j = CL; j > 0; j--) dqPipe[j] = dqPipe[j-1];
    dqPipe[0] = '0;
    if (!sdCsN && !sdRasN && sdCasN) openRow[sdBank] = sdAddr;
    if (!sdCsN && sdRasN && !sdCasN) dqPipe[0] = memWord(sdBank, openRow[sdBank], sdAddr[8:0]);
    sdDq = dqPipe[CL];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkReset();
    @(negedge clk); #1;
    chk(sdCsN === 1'b1, "R1", "csN after reset", {31'd0, sdCsN}, 32'd1);
    chk(rdValid === 1'b0, "R1", "rdValid after reset", {31'd0, rdValid}, 32'd0);
    chk(reqReady === 1'b1, "R1", "ready after reset", {31'd0, reqReady}, 32'd1);
  endtask

  task automatic runBurst(input logic [1:0] b, input logic [12:0] r, input logic [8:0] c,
                          input logic [1:0] apw, input bit poke);
    int idle, vstart, beat;
    logic [3:0] cmd, expCmd;
    logic [8:0] expCol;
    idle   = AW + CL + 8;
    vstart = AW + CL + 3;
    @(negedge clk);
    apWait = apw; reqBank = b; reqRow = r; reqCol = c; reqValid = 1'b1;
    #1 chk(reqReady === 1'b1, "R7", "ready before accept", {31'd0, reqReady}, 32'd1);
    @(posedge clk);
    for (int t = 1; t <= idle + apw + 1; t++) begin
      @(negedge clk);
      if (t == 1) reqValid = 1'b0;
      if (poke && t == 3) begin reqValid = 1'b1; reqBank = b ^ 2'd1; end
      if (poke && t == idle - 1) begin reqValid = 1'b0; reqBank = b; end
      #1;
      cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
      if (t == 1) begin
        chk(cmd === 4'b0011, "R2", "activate cmd", {28'd0, cmd}, 32'h3);
        chk(sdAddr === r, "R2", "row address", {19'd0, sdAddr}, {19'd0, r});
        chk(sdBank === b, "R2", "bank", {30'd0, sdBank}, {30'd0, b});
      end else if (t >= AW + 2 && t <= AW + 5) begin
        beat   = t - AW - 2;
        expCol = {c[8:2], 2'(beat)};
        chk(cmd === 4'b0101, "R3", "read cmd", {28'd0, cmd}, 32'h5);
        chk(sdAddr[8:0] === expCol, "R3", "column", {23'd0, sdAddr[8:0]}, {23'd0, expCol});
        chk(sdAddr[10] === (beat == 3), "R4", "auto-precharge bit",
            {31'd0, sdAddr[10]}, {31'd0, beat == 3});
        chk(sdDqm === 4'h0, "R5", "mask on read", {28'd0, sdDqm}, 32'h0);
      end else begin
        expCmd = 4'b1111;
        chk(cmd === expCmd, poke ? "R7" : "R5", "nop cmd", {28'd0, cmd}, {28'd0, expCmd});
        chk(sdDqm === 4'hF, "R5", "mask on nop", {28'd0, sdDqm}, 32'hF);
      end
      if (t >= vstart && t <= vstart + 3) begin
        beat   = t - vstart;
        expCol = {c[8:2], 2'(beat)};
        chk(rdValid === 1'b1, "R6", "rdValid", {31'd0, rdValid}, 32'd1);
        chk(rdBeat === 2'(beat), "R6", "beat tag", {30'd0, rdBeat}, beat);
        chk(rdData === memWord(b, r, expCol), "R6", "data", rdData, memWord(b, r, expCol));
      end else begin
        chk(rdValid === 1'b0, "R6", "rdValid idle", {31'd0, rdValid}, 32'd0);
      end
      if (t < idle)
        chk(reqReady === 1'b0, "R7", "ready while busy", {31'd0, reqReady}, 32'd0);
      else
        chk(reqReady === (t >= idle + apw + 1), "R8", "same-bank ready",
            {31'd0, reqReady}, {31'd0, t >= idle + apw + 1});
      if (t == idle) begin
        reqBank = b ^ 2'd2;
        #1 chk(reqReady === 1'b1, "R9", "other bank ready", {31'd0, reqReady}, 32'd1);
        reqBank = b;
        #1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    checkReset();
    runBurst(2'd0, 13'h0ABC, 9'h040, 2'd0, 1'b0);
    runBurst(2'd1, 13'h1234, 9'h1F3, 2'd2, 1'b0);
    runBurst(2'd2, 13'h0F0F, 9'h0A5, 2'd3, 1'b1);
    runBurst(2'd3, 13'h1FFF, 9'h1FE, 2'd1, 1'b0);
    runBurst(2'd3, 13'h0001, 9'h003, 2'd0, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule